// File: doc/BRIEF.md
# LIN Slave Header Auto-Baud Synchronizer

This block sits in the receive path of a LIN slave. It runs on the oversampling clock and watches the serial receive line. It looks for a break: a long dominant (low) stretch followed by a recessive (high) delimiter. It then times the sync byte that follows. From that timing it derives a fresh baud divider. The divider has two parts: an integer clock-divide value, and a 3-bit fraction in eighths of a sampling clock.

Only one thing is measured: the number of sampling clocks across the eight bit periods between the first and the last falling edge of the sync byte. The low three bits of that count become the fraction, and the rest becomes the integer divider. At the same time the byte is sampled at mid-bit, using the divider currently in force. If the byte is not 0x55, if the stop bit is wrong, or if the count overflows, the block flags an inconsistent sync field and leaves the divider untouched.

Top module: `lin_sync_slave`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after reset, `cd_out` equals `cd_init` and `fp_out` equals `fp_init`, and neither strobe is raised.
- R2: A break is accepted only if the line stays low for at least `BREAK_BITS*cd_out` sampling clocks (13 bit times by default) before rising. A low stretch one clock shorter is ignored.
- R3: After an accepted break, the line must stay high for at least `cd_out` sampling clocks before the next falling edge, which is the sync start bit. A delimiter one clock shorter is ignored, and the search for a break begins again.
- R4: The count is the number of sampling clocks from the falling edge of the start bit to the fourth falling edge after it (eight bit periods for 0x55). On success, `cd_out` takes count bits [CNT_W-1:3] and `fp_out` takes count bits [2:0], and `sync_done` pulses for one cycle.
- R5: The frame is sampled at mid-bit using the current `cd_out`: half a divider after the start edge, then one divider apart. The start bit must be 0, the eight data bits (LSB first) must equal 0x55, and the stop bit must be 1. Any other value raises `sync_err` for one cycle and leaves `cd_out` and `fp_out` unchanged.
- R6: The counter saturates at all ones. A count that reaches the all-ones value is an overflow: `sync_err` pulses and the divider is kept.
- R7: While `en` is low, no header is detected, a measurement in progress is dropped, neither strobe is raised, and the divider is kept.
- R8: `sync_done` and `sync_err` are single-cycle pulses, never high together. One of them is issued at the stop-bit sample, after which the block returns to break search, so a following header is measured with the updated divider.
- R9: Between strobes, `cd_out` and `fp_out` hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oversampling clock |
| rst_n | input | 1 | Synchronous reset, active low |
| en | input | 1 | Enables header search and measurement |
| rxd | input | 1 | Serial receive line (asynchronous) |
| cd_init | input | CNT_W-3 | Integer divider loaded at reset |
| fp_init | input | 3 | Fractional divider loaded at reset |
| cd_out | output | CNT_W-3 | Current integer clock divider |
| fp_out | output | 3 | Current fractional divider, eighths of a clock |
| sync_done | output | 1 | One-cycle pulse: new divider loaded |
| sync_err | output | 1 | One-cycle pulse: inconsistent sync field |

## Verification
The hardest case to reach is counter saturation. The counter must hit all ones while the mid-bit sampler still accepts the frame, and that only happens when the divider in force is at its largest value. The bench therefore builds the block with a 10-bit counter and resets it to the maximum divider of 127. It then sends sync bytes whose eight-bit span is 1022, 1023 and 1040 clocks, which puts the count just below, exactly at and beyond the all-ones value. Fractional bit lengths are produced by placing each edge at floor(k*P/8) clocks, so every value of the fraction appears in the sweeps.

// File: rtl/lin_sync_pkg.sv
package lin_sync_pkg;

    typedef enum logic [0:0] {
        BK_SEEK  = 1'b0,
        BK_DELIM = 1'b1
    } brk_state_e;

    localparam int FRAME_BITS  = 10;     // start + 8 data + stop
    localparam int EDGE_TARGET = 4;      // falls after the start edge
    localparam logic [7:0] SYNC_BYTE = 8'h55;

endpackage

// File: rtl/lin_rx_front.sv
module lin_rx_front #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic rxd,
    output logic rx_lvl,
    output logic rx_fall,
    output logic rx_rise
);
    typedef struct packed {
        logic [SYNC_STAGES-1:0] sh;
        logic                   prev;
    } front_t;

    front_t q, d;

    always_comb begin
        d      = q;
        d.sh   = {q.sh[SYNC_STAGES-2:0], rxd};
        d.prev = q.sh[SYNC_STAGES-1];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '1;
        else        q <= d;
    end

    assign rx_lvl  = q.sh[SYNC_STAGES-1];
    assign rx_fall = q.prev & ~rx_lvl;
    assign rx_rise = ~q.prev & rx_lvl;

    // R2: a detected fall is never immediately followed by a second one
    p_fall_spacing_r2: assert property (@(posedge clk) disable iff (!rst_n)
        rx_fall |=> !rx_fall);
endmodule

// File: rtl/lin_break_det.sv
module lin_break_det
    import lin_sync_pkg::*;
#(
    parameter int CD_W       = 16,
    parameter int BREAK_BITS = 13
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            act,
    input  logic            rx_lvl,
    input  logic            rx_fall,
    input  logic            rx_rise,
    input  logic [CD_W-1:0] cd,
    output logic            hdr_start
);
    localparam int LO_W = CD_W + $clog2(BREAK_BITS + 1);
    localparam int HI_W = CD_W + 1;

    typedef struct packed {
        brk_state_e       st;
        logic [LO_W-1:0]  lo;
        logic [HI_W-1:0]  hi;
    } brk_t;

    brk_t q, d;
    logic [LO_W-1:0] lim;

    assign lim = LO_W'(BREAK_BITS) * LO_W'(cd);

    always_comb begin
        d         = q;
        hdr_start = 1'b0;
        if (!act) begin
            d.st = BK_SEEK;
            d.lo = '0;
            d.hi = '0;
        end else begin
            unique case (q.st)
                BK_SEEK: begin
                    if (!rx_lvl && q.lo != '1) d.lo = q.lo + LO_W'(1);
                    if (rx_rise) begin
                        d.lo = '0;
                        if (q.lo >= lim) begin
                            d.st = BK_DELIM;
                            d.hi = HI_W'(1);
                        end
                    end
                end
                BK_DELIM: begin
                    if (rx_lvl && q.hi != '1) d.hi = q.hi + HI_W'(1);
                    if (rx_fall) begin
                        d.st = BK_SEEK;
                        d.hi = '0;
                        if (q.hi >= HI_W'(cd)) begin
                            hdr_start = 1'b1;
                            d.lo      = '0;
                        end else begin
                            d.lo = LO_W'(1);
                        end
                    end
                end
                default: d.st = BK_SEEK;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q.st <= BK_SEEK;
            q.lo <= '0;
            q.hi <= '0;
        end else begin
            q <= d;
        end
    end

    // R2: the delimiter phase is entered only after a long enough low stretch
    p_delim_entry_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(q.st == BK_DELIM) |-> $past(q.lo >= lim));
    // R3: a header start always sends the detector back to break search
    p_start_returns_r3: assert property (@(posedge clk) disable iff (!rst_n)
        hdr_start |=> q.st == BK_SEEK);
endmodule

// File: rtl/lin_sync_meas.sv
module lin_sync_meas
    import lin_sync_pkg::*;
#(
    parameter int CNT_W = 19,
    parameter int CD_W  = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             act,
    input  logic             start,
    input  logic             rx_lvl,
    input  logic             rx_fall,
    input  logic [CD_W-1:0]  cd,
    output logic             busy,
    output logic             fin,
    output logic             good,
    output logic [CNT_W-1:0] cap
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;
    localparam logic [3:0] LAST_IDX = 4'(FRAME_BITS - 1);

    typedef struct packed {
        logic                  busy;
        logic [CNT_W-1:0]      cnt;
        logic [2:0]            fe;
        logic [CNT_W-1:0]      cap;
        logic [CD_W-1:0]       tmr;
        logic [3:0]            idx;
        logic [FRAME_BITS-1:0] smp;
    } meas_t;

    meas_t q, d;
    logic [FRAME_BITS-1:0] frame;
    logic                  frame_ok;

    always_comb begin
        frame    = {rx_lvl, q.smp[FRAME_BITS-2:0]};
        frame_ok = !frame[0] && (frame[8:1] == SYNC_BYTE) && frame[FRAME_BITS-1];
    end

    always_comb begin
        d    = q;
        fin  = 1'b0;
        good = 1'b0;
        if (!act) begin
            d.busy = 1'b0;
        end else if (!q.busy) begin
            if (start) begin
                d.busy = 1'b1;
                d.cnt  = CNT_W'(1);
                d.fe   = '0;
                d.cap  = '0;
                d.tmr  = cd >> 1;
                d.idx  = '0;
                d.smp  = '0;
            end
        end else begin
            if (q.cnt != CNT_MAX) d.cnt = q.cnt + CNT_W'(1);
            if (rx_fall && q.fe != 3'(EDGE_TARGET)) begin
                d.fe = q.fe + 3'd1;
                if (q.fe == 3'(EDGE_TARGET - 1)) d.cap = q.cnt;
            end
            if (q.tmr == '0) begin
                d.smp[q.idx] = rx_lvl;
                d.tmr        = cd - CD_W'(1);
                d.idx        = q.idx + 4'd1;
                if (q.idx == LAST_IDX) begin
                    fin    = 1'b1;
                    d.busy = 1'b0;
                    good   = frame_ok && (q.fe == 3'(EDGE_TARGET)) && (q.cap != CNT_MAX);
                end
            end else begin
                d.tmr = q.tmr - CD_W'(1);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign busy = q.busy;
    assign cap  = q.cap;

    // R6: once saturated, the counter never wraps during a measurement
    p_no_overflow_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (q.busy && q.cnt == CNT_MAX) |=> (!q.busy || q.cnt == CNT_MAX));
    // R5: the sample index stays inside the frame
    p_idx_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
        q.busy |-> q.idx <= LAST_IDX);
    // R8: the measurement ends with the stop-bit sample
    p_fin_ends_r8: assert property (@(posedge clk) disable iff (!rst_n)
        fin |=> !q.busy);
endmodule

// File: rtl/lin_sync_slave.sv
module lin_sync_slave #(
    parameter int CNT_W       = 19,
    parameter int BREAK_BITS  = 13,
    parameter int SYNC_STAGES = 2,
    localparam int FP_W = 3,
    localparam int CD_W = CNT_W - FP_W
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            en,
    input  logic            rxd,
    input  logic [CD_W-1:0] cd_init,
    input  logic [FP_W-1:0] fp_init,
    output logic [CD_W-1:0] cd_out,
    output logic [FP_W-1:0] fp_out,
    output logic            sync_done,
    output logic            sync_err
);
    typedef struct packed {
        logic [CD_W-1:0] cd;
        logic [FP_W-1:0] fp;
        logic            done;
        logic            err;
    } top_t;

    top_t q, d;

    logic             rx_lvl, rx_fall, rx_rise;
    logic             hdr_start, busy, fin, good;
    logic [CNT_W-1:0] cap;

    lin_rx_front #(.SYNC_STAGES(SYNC_STAGES)) front_i (
        .clk(clk), .rst_n(rst_n), .rxd(rxd),
        .rx_lvl(rx_lvl), .rx_fall(rx_fall), .rx_rise(rx_rise)
    );

    lin_break_det #(.CD_W(CD_W), .BREAK_BITS(BREAK_BITS)) brk_i (
        .clk(clk), .rst_n(rst_n), .act(en && !busy),
        .rx_lvl(rx_lvl), .rx_fall(rx_fall), .rx_rise(rx_rise),
        .cd(q.cd), .hdr_start(hdr_start)
    );

    lin_sync_meas #(.CNT_W(CNT_W), .CD_W(CD_W)) meas_i (
        .clk(clk), .rst_n(rst_n), .act(en), .start(hdr_start),
        .rx_lvl(rx_lvl), .rx_fall(rx_fall), .cd(q.cd),
        .busy(busy), .fin(fin), .good(good), .cap(cap)
    );

    always_comb begin
        d      = q;
        d.done = 1'b0;
        d.err  = 1'b0;
        if (en && fin) begin
            if (good) begin
                d.cd   = cap[CNT_W-1:FP_W];
                d.fp   = cap[FP_W-1:0];
                d.done = 1'b1;
            end else begin
                d.err  = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q.cd   <= cd_init;
            q.fp   <= fp_init;
            q.done <= 1'b0;
            q.err  <= 1'b0;
        end else begin
            q <= d;
        end
    end

    assign cd_out    = q.cd;
    assign fp_out    = q.fp;
    assign sync_done = q.done;
    assign sync_err  = q.err;

    // R8: the two strobes never coincide
    p_strobe_excl_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !(sync_done && sync_err));
    // R8: success strobe lasts one cycle
    p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
        sync_done |=> !sync_done);
    // R9: the divider changes only together with a success strobe
    p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !d.done |=> ($stable(cd_out) && $stable(fp_out)));
    // R7: disabled block raises no strobe
    p_off_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> (!sync_done && !sync_err));
    // R5: an error strobe leaves the divider as it was
    p_err_keeps_r5: assert property (@(posedge clk) disable iff (!rst_n)
        sync_err |-> ($stable(cd_out) && $stable(fp_out)));
endmodule

// File: tb/lin_sync_slave_tb_top.sv
module lin_sync_slave_tb_top;
    localparam int CW  = 10;
    localparam int CDW = CW - 3;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           en = 1'b1;
    logic           rxd = 1'b1;
    logic [CDW-1:0] cd_init = 7'd16;
    logic [2:0]     fp_init = 3'd0;
    logic [CDW-1:0] cd_out;
    logic [2:0]     fp_out;
    logic           sync_done, sync_err;

    int n_tests = 0, n_fail = 0;
    int done_cnt = 0, err_cnt = 0, cyc = 0;
    bit finished = 0;

    lin_sync_slave #(.CNT_W(CW)) dut_i (
        .clk(clk), .rst_n(rst_n), .en(en), .rxd(rxd),
        .cd_init(cd_init), .fp_init(fp_init),
        .cd_out(cd_out), .fp_out(fp_out),
        .sync_done(sync_done), .sync_err(sync_err)
    );

    always #10 clk = ~clk;

    always @(negedge clk) begin
        cyc <= cyc + 1;
        if (sync_done) done_cnt <= done_cnt + 1;
        if (sync_err)  err_cnt  <= err_cnt + 1;
    end

    always @(posedge clk) begin
        if (cyc >= 190000 && !finished) begin
            finished = 1;
            n_fail++;
            $display("FAIL R8 watchdog: cycles %0d expected below %0d", cyc, 190000);
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic hold(input logic v, input int n);
        repeat (n) begin
            @(negedge clk);
            rxd = v;
        end
    endtask

    task automatic do_reset(input int cd, input int fp);
        @(negedge clk);
        rst_n   = 1'b0;
        cd_init = CDW'(cd);
        fp_init = 3'(fp);
        hold(1'b1, 3);
        rst_n = 1'b1;
        hold(1'b1, 4);
    endtask

    // break of brk clocks, delimiter of del clocks, frame with bit k starting at floor(k*p/8)
    task automatic send_hdr(input int brk, input int del, input int p,
                            input logic [7:0] b, input logic stopb);
        hold(1'b0, brk);
        hold(1'b1, del);
        for (int k = 0; k < 10; k++) begin
            logic v;
            v = (k == 0) ? 1'b0 : (k == 9) ? stopb : b[k-1];
            hold(v, ((k + 1) * p) / 8 - (k * p) / 8);
        end
        hold(1'b1, p / 2 + 24);
    endtask

    task automatic run(input string req, input int brk, input int del, input int p,
                       input logic [7:0] b, input logic stopb,
                       input int e_done, input int e_err, input int e_cd, input int e_fp);
        int d0, e0;
        d0 = done_cnt;
        e0 = err_cnt;
        send_hdr(brk, del, p, b, stopb);
        chk(done_cnt - d0 == e_done, req, "done pulses", done_cnt - d0, e_done);
        chk(err_cnt - e0 == e_err, req, "err pulses", err_cnt - e0, e_err);
        chk(cd_out == CDW'(e_cd), req, "cd_out", int'(cd_out), e_cd);
        chk(fp_out == 3'(e_fp), req, "fp_out", int'(fp_out), e_fp);
    endtask

    initial begin
        // R1: reset loads the initial divider, no strobes
        hold(1'b1, 2);
        chk(!sync_done && !sync_err, "R1", "strobes in reset", int'(sync_done | sync_err), 0);
        do_reset(16, 3);
        chk(cd_out == 7'd16, "R1", "cd after reset", int'(cd_out), 16);
        chk(fp_out == 3'd3, "R1", "fp after reset", int'(fp_out), 3);
        chk(done_cnt == 0 && err_cnt == 0, "R1", "strobes after reset", done_cnt + err_cnt, 0);

        // R4: sweep of dividers and fractional bit lengths
        for (int ci = 0; ci < 3; ci++) begin
            int cd;
            cd = 12 + 4 * ci;
            for (int p = 8 * cd - cd / 4 + 1; p <= 8 * cd + cd / 4 - 1; p++) begin
                do_reset(cd, 0);
                run("R4", (14 * p) / 8, (2 * p) / 8, p, 8'h55, 1'b1, 1, 0, p >> 3, p & 7);
                // R8: second header measured with the updated divider
                run("R8", 14 * (p >> 3), 2 * (p >> 3), 8 * (p >> 3), 8'h55, 1'b1,
                    1, 0, p >> 3, 0);
            end
        end

        // R2: break length boundary at 13 bit times
        do_reset(16, 2);
        run("R2", 207, 32, 128, 8'h55, 1'b1, 0, 0, 16, 2);
        run("R2", 208, 32, 130, 8'h55, 1'b1, 1, 0, 16, 2);

        // R3: delimiter length boundary at one bit time
        do_reset(16, 1);
        run("R3", 224, 15, 128, 8'h55, 1'b1, 0, 0, 16, 1);
        run("R3", 224, 16, 129, 8'h55, 1'b1, 1, 0, 16, 1);

        // R7: disabled block ignores a valid header
        do_reset(16, 4);
        en = 1'b0;
        run("R7", 224, 32, 136, 8'h55, 1'b1, 0, 0, 16, 4);
        en = 1'b1;
        run("R7", 224, 32, 136, 8'h55, 1'b1, 1, 0, 17, 0);

        // R5: every sync byte value; only 0x55 succeeds, divider kept on error (R9)
        do_reset(12, 0);
        for (int b = 0; b < 256; b++) begin
            int ok;
            ok = (b == 8'h55) ? 1 : 0;
            run("R5", 168, 24, 96, 8'(b), 1'b1, ok, 1 - ok, 12, 0);
        end
        // R5: bad stop bit
        run("R5", 168, 24, 97, 8'h55, 1'b0, 0, 1, 12, 0);

        // R6: counter saturation at the largest divider
        do_reset(127, 0);
        run("R6", (14 * 1022) / 8, 256, 1022, 8'h55, 1'b1, 1, 0, 127, 6);
        run("R6", (14 * 1023) / 8, 256, 1023, 8'h55, 1'b1, 0, 1, 127, 6);
        run("R6", (14 * 1040) / 8, 256, 1040, 8'h55, 1'b1, 0, 1, 127, 6);

        // R9: divider still held after idle time
        hold(1'b1, 300);
        chk(cd_out == 7'd127 && fp_out == 3'd6, "R9", "held divider",
            int'(cd_out) * 8 + int'(fp_out), 127 * 8 + 6);

        finished = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule